// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block is the transfer engine on the master side of an I2C controller. It takes command entries from a show-ahead transmit FIFO. Each entry carries a direction bit, a data byte and a stop tag. From these entries it drives a bit-timing engine one bus operation at a time: START, the address phase, byte writes, byte reads and STOP. The bit-timing engine is outside this block and uses a request/done handshake.

The target configuration has four parts: a 10-bit target address, a 7/10-bit addressing select, a special-transfer flag and a flag that chooses between general call and START byte. The block copies this configuration when it issues a START, so software may rewrite it at any time.

A transfer ends only after an entry that carries the stop tag. If the FIFO runs dry before such an entry arrives, the block holds SCL low and waits. A NACK on an address byte or a written data byte aborts the transfer. While the block is disabled, the FIFO is held clear.

Top module: `i2c_cmd_seq`

## Requirements
- R1: After reset, `busy`, `bit_req`, `scl_hold`, `abort` and `fifo_pop` are all 0.
- R2: Bus operations are coded on `bit_op` as 0=START, 1=STOP, 2=byte write, 3=byte read. A write entry (`fifo_dir`=0) in 7-bit mode produces START, then the byte {target[6:0], 0}, then each entry's data byte in FIFO order.
- R3: A read entry (`fifo_dir`=1) produces a byte read. `bit_ack_n` is 0 for reads, except on a stop-tagged entry where it is 1. One cycle after each read completes, `rd_valid` pulses with the received byte on `rd_data`.
- R4: If the next entry's direction differs from the current one and no STOP came between them, the block issues a repeated START and readdresses the target with the new direction bit.
- R5: In 10-bit mode a write sends START, {11110, target[9:8], 0}, then target[7:0]. A read sends the same bytes, then a repeated START, then {11110, target[9:8], 1}.
- R6: General call (special=1, select=0) sends the address byte 0x00. Every entry is then written as data, whatever its direction bit.
- R7: START byte (special=1, select=1) sends START, writes 0x01, issues a repeated START, and then performs a normal addressed transfer.
- R8: STOP is issued only after a stop-tagged entry completes. If the FIFO is empty and no stop tag has been seen, `scl_hold` is 1, no bus operation is requested, and the transfer resumes when a new entry arrives.
- R9: The target configuration is captured at each START. A change made while a transfer is in progress affects only later transfers.
- R10: A NACK on an address byte or a written data byte causes a STOP and a one-cycle `fifo_clear`. `abort` is set and stays set until the next START.
- R11: While `cfg_en` is 0, `fifo_clear` is held at 1 and no transfer starts. Disabling the block while it is stalled ends the transfer with a STOP.
- R12: `bit_req` stays high with a stable `bit_op` and `bit_wdata` until `bit_done`. `fifo_pop` is asserted only when the FIFO is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Block enable |
| cfg_tar | input | 10 | Target address |
| cfg_addr10 | input | 1 | 1 = 10-bit addressing |
| cfg_special | input | 1 | 1 = general call or START byte |
| cfg_sbyte | input | 1 | With special: 1 = START byte, 0 = general call |
| fifo_empty | input | 1 | FIFO has no entry |
| fifo_dir | input | 1 | Head entry direction, 1 = read |
| fifo_stop | input | 1 | Head entry stop tag |
| fifo_data | input | 8 | Head entry data byte |
| fifo_pop | output | 1 | Consume the head entry |
| fifo_clear | output | 1 | Flush the FIFO |
| bit_req | output | 1 | Bus operation request |
| bit_op | output | 2 | Operation code |
| bit_wdata | output | 8 | Byte to write |
| bit_ack_n | output | 1 | Acknowledge bit the master drives after a read |
| bit_done | input | 1 | Operation finished (one-cycle pulse) |
| bit_nack | input | 1 | Slave NACK on a write, valid with done |
| bit_rdata | input | 8 | Byte read, valid with done |
| rd_valid | output | 1 | Read byte available |
| rd_data | output | 8 | Read byte |
| scl_hold | output | 1 | Stalled with SCL held low |
| busy | output | 1 | Transfer in progress |
| abort | output | 1 | Last transfer aborted on NACK |

## Verification
A wrong state register shows up on the very next bus request. It appears as a wrong operation code, a wrong address byte, a START or STOP that should not be there, or one that is missing. The scoreboard reports it when the engine model accepts that request, which is a few cycles after the fault.

A stale direction or configuration register gives away a wrong R/W bit or a wrong address on the next address phase. A broken stall or flush path shows up on `scl_hold`, on `abort`, or as leftover FIFO entries appearing on the bus within one transfer.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  localparam int BYTE_W = 8;
  localparam int TAR_W  = 10;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } bus_op_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_START,
    ST_SBYTE,
    ST_RS,
    ST_HDR,
    ST_LOW,
    ST_RS10,
    ST_HDRR,
    ST_DATA,
    ST_XFER,
    ST_STOP
  } seq_st_e;

  typedef struct packed {
    logic [TAR_W-1:0] tar;
    logic             addr10;
    logic             special;
    logic             sbyte;
  } tgt_cfg_t;
endpackage

// File: rtl/i2c_seq_rst_sync.sv
module i2c_seq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) shreg <= '0;
    else           shreg <= {shreg[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = shreg[STAGES-1];
endmodule

// File: rtl/i2c_seq_cfg_latch.sv
module i2c_seq_cfg_latch
  import i2c_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  tgt_cfg_t cfg_in,
  output tgt_cfg_t cfg_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cfg_q <= '0;
    else if (load) cfg_q <= cfg_in;
  end
endmodule

// File: rtl/i2c_seq_addr_gen.sv
module i2c_seq_addr_gen
  import i2c_seq_pkg::*;
(
  input  tgt_cfg_t          cfg,
  input  logic              dir,
  output logic [BYTE_W-1:0] first_byte,
  output logic [BYTE_W-1:0] low_byte,
  output logic [BYTE_W-1:0] hdr_rd,
  output logic              is_gc,
  output logic              ten_bit
);
  localparam logic [4:0] HDR_PFX = 5'b11110;

  always_comb begin
    is_gc    = cfg.special & ~cfg.sbyte;
    ten_bit  = cfg.addr10 & ~is_gc;
    low_byte = cfg.tar[BYTE_W-1:0];
    hdr_rd   = {HDR_PFX, cfg.tar[TAR_W-1:BYTE_W], 1'b1};
    if (is_gc)           first_byte = '0;
    else if (cfg.addr10) first_byte = {HDR_PFX, cfg.tar[TAR_W-1:BYTE_W], 1'b0};
    else                 first_byte = {cfg.tar[BYTE_W-2:0], dir};
  end
endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq
  import i2c_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic [TAR_W-1:0]  cfg_tar,
  input  logic              cfg_addr10,
  input  logic              cfg_special,
  input  logic              cfg_sbyte,
  input  logic              fifo_empty,
  input  logic              fifo_dir,
  input  logic              fifo_stop,
  input  logic [BYTE_W-1:0] fifo_data,
  output logic              fifo_pop,
  output logic              fifo_clear,
  output logic              bit_req,
  output logic [1:0]        bit_op,
  output logic [BYTE_W-1:0] bit_wdata,
  output logic              bit_ack_n,
  input  logic              bit_done,
  input  logic              bit_nack,
  input  logic [BYTE_W-1:0] bit_rdata,
  output logic              rd_valid,
  output logic [BYTE_W-1:0] rd_data,
  output logic              scl_hold,
  output logic              busy,
  output logic              abort
);
  logic rst_n_s;

  i2c_seq_rst_sync #(.STAGES(2)) u_rst (
    .clk      (clk),
    .rst_n_in (rst_n),
    .rst_n_out(rst_n_s)
  );

  seq_st_e           st_q, st_d;
  logic              dir_q, dir_d;
  logic [BYTE_W-1:0] cap_data_q;
  logic              cap_stop_q, cap_dir_q;
  logic              abort_d, rdv_d;
  logic              ld_cfg, clr_pulse;
  tgt_cfg_t          cfg_live, cfg_q;
  logic [BYTE_W-1:0] first_byte, low_byte, hdr_rd;
  logic              is_gc, ten_bit, live_gc;

  assign cfg_live = '{tar: cfg_tar, addr10: cfg_addr10, special: cfg_special, sbyte: cfg_sbyte};
  assign live_gc  = cfg_special & ~cfg_sbyte;

  i2c_seq_cfg_latch u_cfg (
    .clk   (clk),
    .rst_n (rst_n_s),
    .load  (ld_cfg),
    .cfg_in(cfg_live),
    .cfg_q (cfg_q)
  );

  i2c_seq_addr_gen u_addr (
    .cfg       (cfg_q),
    .dir       (dir_q),
    .first_byte(first_byte),
    .low_byte  (low_byte),
    .hdr_rd    (hdr_rd),
    .is_gc     (is_gc),
    .ten_bit   (ten_bit)
  );

  // next-state logic
  always_comb begin
    st_d      = st_q;
    dir_d     = dir_q;
    ld_cfg    = 1'b0;
    fifo_pop  = 1'b0;
    clr_pulse = 1'b0;
    abort_d   = abort;
    rdv_d     = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (cfg_en && !fifo_empty) begin
          st_d    = ST_START;
          ld_cfg  = 1'b1;
          abort_d = 1'b0;
          dir_d   = fifo_dir & ~live_gc;
        end
      end
      ST_START: if (bit_done) st_d = (cfg_q.special && cfg_q.sbyte) ? ST_SBYTE : ST_HDR;
      ST_SBYTE: if (bit_done) st_d = ST_RS;
      ST_RS:    if (bit_done) st_d = ST_HDR;
      ST_HDR: begin
        if (bit_done) begin
          if (bit_nack)     begin st_d = ST_STOP; clr_pulse = 1'b1; abort_d = 1'b1; end
          else if (ten_bit) st_d = ST_LOW;
          else              st_d = ST_DATA;
        end
      end
      ST_LOW: begin
        if (bit_done) begin
          if (bit_nack)   begin st_d = ST_STOP; clr_pulse = 1'b1; abort_d = 1'b1; end
          else if (dir_q) st_d = ST_RS10;
          else            st_d = ST_DATA;
        end
      end
      ST_RS10: if (bit_done) st_d = ST_HDRR;
      ST_HDRR: begin
        if (bit_done) begin
          if (bit_nack) begin st_d = ST_STOP; clr_pulse = 1'b1; abort_d = 1'b1; end
          else          st_d = ST_DATA;
        end
      end
      ST_DATA: begin
        if (!cfg_en) begin
          st_d = ST_STOP;
        end else if (!fifo_empty) begin
          if (!is_gc && (fifo_dir != dir_q)) begin
            dir_d = fifo_dir;
            st_d  = ST_RS;
          end else begin
            fifo_pop = 1'b1;
            st_d     = ST_XFER;
          end
        end
      end
      ST_XFER: begin
        if (bit_done) begin
          rdv_d = cap_dir_q;
          if (!cap_dir_q && bit_nack) begin
            st_d = ST_STOP; clr_pulse = 1'b1; abort_d = 1'b1;
          end else begin
            st_d = cap_stop_q ? ST_STOP : ST_DATA;
          end
        end
      end
      ST_STOP: if (bit_done) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st_q       <= ST_IDLE;
      dir_q      <= 1'b0;
      abort      <= 1'b0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      cap_data_q <= '0;
      cap_stop_q <= 1'b0;
      cap_dir_q  <= 1'b0;
    end else begin
      st_q     <= st_d;
      dir_q    <= dir_d;
      abort    <= abort_d;
      rd_valid <= rdv_d;
      if (rdv_d) rd_data <= bit_rdata;
      if (fifo_pop) begin
        cap_data_q <= fifo_data;
        cap_stop_q <= fifo_stop;
        cap_dir_q  <= fifo_dir & ~is_gc;
      end
    end
  end

  // outputs
  always_comb begin
    bit_req   = 1'b1;
    bit_op    = OP_WRITE;
    bit_wdata = '0;
    unique case (st_q)
      ST_START, ST_RS, ST_RS10: bit_op = OP_START;
      ST_STOP:  bit_op = OP_STOP;
      ST_SBYTE: bit_wdata = 8'h01;
      ST_HDR:   bit_wdata = first_byte;
      ST_LOW:   bit_wdata = low_byte;
      ST_HDRR:  bit_wdata = hdr_rd;
      ST_XFER: begin
        bit_op    = cap_dir_q ? OP_READ : OP_WRITE;
        bit_wdata = cap_dir_q ? '0 : cap_data_q;
      end
      default:  bit_req = 1'b0;
    endcase
  end

  assign bit_ack_n  = (st_q == ST_XFER) & cap_dir_q & cap_stop_q;
  assign scl_hold   = (st_q == ST_DATA) & fifo_empty & cfg_en;
  assign busy       = (st_q != ST_IDLE);
  assign fifo_clear = ~cfg_en | clr_pulse;
endmodule

// File: rtl/i2c_cmd_seq_chk.sv
module i2c_cmd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_en,
  input logic       fifo_empty,
  input logic       fifo_pop,
  input logic       fifo_clear,
  input logic       bit_req,
  input logic [1:0] bit_op,
  input logic [7:0] bit_wdata,
  input logic       bit_done,
  input logic       rd_valid,
  input logic       scl_hold,
  input logic       busy,
  input logic       abort
);
  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_req && !bit_done) |=> (bit_req && $stable(bit_op) && $stable(bit_wdata)));

  // R12
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> !fifo_empty);

  // R11
  disabled_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |-> fifo_clear);

  // R10
  abort_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(abort) |-> $past(fifo_clear));

  // R3
  rd_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(bit_done && bit_op == 2'd3));

  // R8
  stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_hold |-> (!bit_req && busy));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bit_req && !fifo_pop));
endmodule

bind i2c_cmd_seq i2c_cmd_seq_chk u_chk (.*);

// File: tb/tb_i2c_cmd_seq.sv
`timescale 1ns/1ps
module tb_i2c_cmd_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_en = 1'b0;
  logic [9:0] cfg_tar = 10'h05A;
  logic       cfg_addr10 = 1'b0, cfg_special = 1'b0, cfg_sbyte = 1'b0;
  logic       fifo_empty = 1'b1, fifo_dir = 1'b0, fifo_stop = 1'b0;
  logic [7:0] fifo_data = '0;
  logic       fifo_pop, fifo_clear, bit_req, bit_ack_n, rd_valid, scl_hold, busy, abort;
  logic [1:0] bit_op;
  logic [7:0] bit_wdata, rd_data;
  logic       bit_done = 1'b0, bit_nack = 1'b0;
  logic [7:0] bit_rdata = '0;

  always #2.5 clk = ~clk;

  i2c_cmd_seq dut (.*);

  int checks = 0, errors = 0;
  logic [9:0] exp_q[$];
  logic [7:0] rd_exp_q[$];
  logic [7:0] rd_pred = 8'h40;
  int nack_byte = -1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // FIFO model (show-ahead)
  logic [9:0] fq[$];
  logic       push_v = 1'b0;
  logic [9:0] push_e = '0;
  always @(posedge clk) begin
    if (fifo_clear) fq.delete();
    else if (fifo_pop && fq.size() > 0) void'(fq.pop_front());
    if (push_v && !fifo_clear) fq.push_back(push_e);
    fifo_empty <= (fq.size() == 0);
    if (fq.size() > 0) begin
      fifo_dir  <= fq[0][9];
      fifo_stop <= fq[0][8];
      fifo_data <= fq[0][7:0];
    end
  end

  // bit engine model and bus-event monitor
  logic       eng_busy = 1'b0;
  int         eng_cnt = 0;
  logic [7:0] rd_seed = 8'h40;
  always @(negedge clk) begin
    if (bit_done) begin
      bit_done = 1'b0;
      bit_nack = 1'b0;
    end else if (eng_busy) begin
      eng_cnt--;
      if (eng_cnt == 0) begin
        eng_busy = 1'b0;
        bit_done = 1'b1;
      end
    end else if (bit_req) begin
      logic [9:0] ev;
      eng_busy = 1'b1;
      eng_cnt  = 2;
      ev = {bit_op, (bit_op == 2'd2) ? bit_wdata : (bit_op == 2'd3) ? {7'b0, bit_ack_n} : 8'h00};
      if (bit_op == 2'd2) bit_nack = (int'(bit_wdata) == nack_byte);
      if (bit_op == 2'd3) begin
        bit_rdata = rd_seed;
        rd_seed++;
      end
      if (exp_q.size() == 0) chk(1'b0, "R2", "unexpected bus event", ev, 0);
      else begin
        logic [9:0] e;
        e = exp_q.pop_front();
        chk(ev == e, "R2/R12", "bus event", ev, e);
      end
    end
  end

  // read-data monitor
  always @(negedge clk) begin
    if (rd_valid) begin
      if (rd_exp_q.size() == 0) chk(1'b0, "R3", "unexpected rd_valid", rd_data, 0);
      else begin
        logic [7:0] e;
        e = rd_exp_q.pop_front();
        chk(rd_data == e, "R3", "rd_data", rd_data, e);
      end
    end
  end

  // driver helpers
  task automatic ev_start();             exp_q.push_back({2'd0, 8'h00}); endtask
  task automatic ev_stop();              exp_q.push_back({2'd1, 8'h00}); endtask
  task automatic ev_wr(input logic [7:0] b); exp_q.push_back({2'd2, b}); endtask
  task automatic ev_rd(input logic last);
    exp_q.push_back({2'd3, 7'b0, last});
    rd_exp_q.push_back(rd_pred);
    rd_pred++;
  endtask

  task automatic push_cmd(input logic dir, input logic stp, input logic [7:0] d);
    @(negedge clk);
    push_v = 1'b1;
    push_e = {dir, stp, d};
    @(negedge clk);
    push_v = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    repeat (4) @(negedge clk);
    while ((exp_q.size() != 0 || busy) && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(exp_q.size() == 0 && !busy, req, "sequence completed, events left", exp_q.size(), 0);
  endtask

  initial begin
    repeat (120000) @(posedge clk);
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(!busy && !bit_req && !scl_hold && !abort && !fifo_pop, "R1", "idle outputs",
        {busy, bit_req, scl_hold, abort, fifo_pop}, 0);
    cfg_en = 1'b1;
    @(negedge clk);

    // R2 7-bit write
    ev_start(); ev_wr(8'hB4); ev_wr(8'h11); ev_wr(8'h22); ev_stop();
    push_cmd(0, 0, 8'h11); push_cmd(0, 1, 8'h22);
    wait_idle("R2");

    // R3 7-bit read, last read NACKed by master
    ev_start(); ev_wr(8'hB5); ev_rd(0); ev_rd(1); ev_stop();
    push_cmd(1, 0, 8'h00); push_cmd(1, 1, 8'h00);
    wait_idle("R3");
    chk(rd_exp_q.size() == 0, "R3", "reads delivered", rd_exp_q.size(), 0);

    // R4 direction change -> repeated START
    ev_start(); ev_wr(8'hB4); ev_wr(8'h33); ev_start(); ev_wr(8'hB5); ev_rd(1); ev_stop();
    push_cmd(0, 0, 8'h33); push_cmd(1, 1, 8'h00);
    wait_idle("R4");

    // R5 10-bit write and read
    cfg_tar = 10'h2C7; cfg_addr10 = 1'b1;
    ev_start(); ev_wr(8'hF4); ev_wr(8'hC7); ev_wr(8'h5C); ev_stop();
    push_cmd(0, 1, 8'h5C);
    wait_idle("R5");
    ev_start(); ev_wr(8'hF4); ev_wr(8'hC7); ev_start(); ev_wr(8'hF5); ev_rd(1); ev_stop();
    push_cmd(1, 1, 8'h00);
    wait_idle("R5");
    cfg_addr10 = 1'b0; cfg_tar = 10'h05A;

    // R6 general call, direction bit ignored
    cfg_special = 1'b1; cfg_sbyte = 1'b0;
    ev_start(); ev_wr(8'h00); ev_wr(8'h77); ev_stop();
    push_cmd(1, 1, 8'h77);
    wait_idle("R6");

    // R7 START byte
    cfg_sbyte = 1'b1;
    ev_start(); ev_wr(8'h01); ev_start(); ev_wr(8'hB4); ev_wr(8'h88); ev_stop();
    push_cmd(0, 1, 8'h88);
    wait_idle("R7");
    cfg_special = 1'b0; cfg_sbyte = 1'b0;

    // R8 stall without stop tag, R9 config change mid-transfer
    ev_start(); ev_wr(8'hB4); ev_wr(8'h10);
    push_cmd(0, 0, 8'h10);
    repeat (60) @(negedge clk);
    chk(scl_hold && busy, "R8", "stalled with SCL low", {scl_hold, busy}, 2'b11);
    chk(exp_q.size() == 0, "R8", "no STOP while stalled", exp_q.size(), 0);
    cfg_tar = 10'h021;
    ev_wr(8'h20); ev_stop();
    push_cmd(0, 1, 8'h20);
    wait_idle("R9");
    chk(!scl_hold, "R8", "hold released", scl_hold, 0);
    ev_start(); ev_wr(8'h42); ev_wr(8'h30); ev_stop();
    push_cmd(0, 1, 8'h30);
    wait_idle("R9");
    cfg_tar = 10'h05A;

    // R10 NACK on address
    nack_byte = 8'hB4;
    ev_start(); ev_wr(8'hB4); ev_stop();
    push_cmd(0, 0, 8'h01); push_cmd(0, 1, 8'h02);
    wait_idle("R10");
    chk(abort, "R10", "abort set", abort, 1);
    chk(fifo_empty, "R10", "FIFO flushed", fifo_empty, 1);
    // R10 NACK on data byte, remaining entry dropped
    nack_byte = 8'h99;
    ev_start(); ev_wr(8'hB4); ev_wr(8'h99); ev_stop();
    push_cmd(0, 0, 8'h99); push_cmd(0, 1, 8'h55);
    wait_idle("R10");
    chk(abort && fifo_empty, "R10", "data NACK abort+flush", {abort, fifo_empty}, 2'b11);
    nack_byte = -1;
    ev_start(); ev_wr(8'hB4); ev_wr(8'h66); ev_stop();
    push_cmd(0, 1, 8'h66);
    repeat (3) @(negedge clk);
    chk(!abort, "R10", "abort cleared at START", abort, 0);
    wait_idle("R10");

    // R11 disabled: writes lost
    cfg_en = 1'b0;
    push_cmd(0, 1, 8'h6A);
    repeat (3) @(negedge clk);
    cfg_en = 1'b1;
    repeat (40) @(negedge clk);
    chk(!busy && fifo_empty, "R11", "no start after disabled write", {busy, fifo_empty}, 2'b01);
    // R11 disable while stalled -> STOP
    ev_start(); ev_wr(8'hB4); ev_wr(8'h70); ev_stop();
    push_cmd(0, 0, 8'h70);
    repeat (40) @(negedge clk);
    chk(scl_hold, "R11", "stalled before disable", scl_hold, 1);
    cfg_en = 1'b0;
    wait_idle("R11");
    chk(!busy && !scl_hold, "R11", "stopped after disable", {busy, scl_hold}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule